// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor

This block is a small 32-bit processor that finishes every instruction in one clock. It runs a nine-instruction subset of a classic load/store instruction set. The register-type operations are add, sub, and, or and slt. The memory operations are lw and sw. The control-flow operations are beq and j.

The design has two halves. A controller decodes the opcode and function fields into control strobes. A datapath holds the program counter, the instruction store, a 32-entry register file, the ALU and the data store, and it returns the ALU zero flag to the controller. The state elements are the program counter, the register file and the two stores, and they update on the rising clock. Everything between them is combinational.

Both stores are word arrays inside the block. They are filled through a word-wide preload port while reset is held. After reset is released, the program counter, the fetched instruction, the register write-back bus and the store bus are visible at the ports for observation.

Top module: `sc_cpu_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0, and no register write or store is signalled (rf_we_o and dm_we_o are 0).
- R2: R-type instructions (opcode 0x00) write rd with rs+rt (funct 0x20), rs-rt (0x22), rs AND rt (0x24) or rs OR rt (0x25), in the same cycle the instruction is at pc_o.
- R3: slt (opcode 0x00, funct 0x2A) writes 1 to rd when rs is less than rt as signed 32-bit values, else 0.
- R4: Register 0 always reads as zero; a write aimed at it leaves rf_we_o low and has no effect.
- R5: lw (opcode 0x23) reads the data word at rs plus the sign-extended 16-bit offset and writes it to rt.
- R6: sw (opcode 0x2B) raises dm_we_o with dm_addr_o equal to rs plus the sign-extended offset and dm_wdata_o equal to rt; a later lw from that address returns the stored word.
- R7: beq (opcode 0x04) makes the next PC equal to PC+4 plus the sign-extended offset shifted left by 2 when rs equals rt, and PC+4 otherwise; it writes nothing.
- R8: j (opcode 0x02) makes the next PC equal to {PC+4 bits 31:28, target[25:0], 2'b00}; it writes nothing.
- R9: An opcode outside the set, or an R-type funct outside the set, writes no register and stores nothing, and the PC advances by 4.
- R10: During reset, load_en_i writes load_data_i into the word at load_addr_i of the instruction store (load_dmem_i=0) or of the data store (load_dmem_i=1).
- R11: Every instruction other than beq and j advances the PC by exactly 4 per clock, and pc_o stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Preload write strobe |
| load_dmem_i | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr_i | input | LAW (6) | Preload word index |
| load_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction at pc_o |
| rf_we_o | output | 1 | Register write-back occurs at the next edge |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Store occurs at the next edge |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Store data |

## Verification
A wrong decode or ALU selection shows up in the same cycle as the faulty instruction, as a wrong value or strobe on the write-back or store bus. A corrupted register or data word stays hidden until a later instruction reads it. That read shows up one or more instructions later as a wrong write-back value or store value. A bad next-PC computation appears on pc_o at the very next clock. After that, every following fetch is off-path, so all later expectations diverge.

// File: rtl/sc_cpu_pkg.sv
`timescale 1ns/1ps
package sc_cpu_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT} alu_fn_e;
  typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_FUNCT} alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_imm;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_cpu_ctrl.sv
`timescale 1ns/1ps
module sc_cpu_ctrl
  import sc_cpu_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic       zero_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o,
  output logic       pc_branch_o
);
  ctrl_t main_d;
  logic  fn_ok;

  always_comb begin
    main_d = '0;
    main_d.alu_op = AOP_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        main_d.reg_dst   = 1'b1;
        main_d.reg_write = 1'b1;
        main_d.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        main_d.alu_imm    = 1'b1;
        main_d.mem_to_reg = 1'b1;
        main_d.reg_write  = 1'b1;
      end
      OP_SW: begin
        main_d.alu_imm   = 1'b1;
        main_d.mem_write = 1'b1;
      end
      OP_BEQ: begin
        main_d.branch = 1'b1;
        main_d.alu_op = AOP_SUB;
      end
      OP_J:    main_d.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    fn_ok    = 1'b1;
    alu_fn_o = ALU_ADD;
    unique case (main_d.alu_op)
      AOP_SUB:   alu_fn_o = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct_i)
          FN_ADD:  alu_fn_o = ALU_ADD;
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: fn_ok    = 1'b0;
        endcase
      end
      default: alu_fn_o = ALU_ADD;
    endcase
  end

  // unknown funct suppresses write-back
  always_comb begin
    ctrl_o           = main_d;
    ctrl_o.reg_write = main_d.reg_write & fn_ok;
  end

  assign pc_branch_o = main_d.branch & zero_i;
endmodule

// File: rtl/sc_cpu_regfile.sv
`timescale 1ns/1ps
module sc_cpu_regfile #(
  parameter  int NREG = 32,
  parameter  int XLEN = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] rd_vec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rd_vec[g] = '0;
    end else begin : g_flop
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= '0;
        else if (we_i && waddr_i == AW'(g))   q <= wdata_i;
      end
      assign rd_vec[g] = q;
    end
  end

  assign rdata_a_o = rd_vec[raddr_a_i];
  assign rdata_b_o = rd_vec[raddr_b_i];
endmodule

// File: rtl/sc_cpu_alu.sv
`timescale 1ns/1ps
module sc_cpu_alu
  import sc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_cpu_dpath.sv
`timescale 1ns/1ps
module sc_cpu_dpath
  import sc_cpu_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  parameter  int LAW        = 6,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_dmem_i,
  input  logic [LAW-1:0]    load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  input  ctrl_t             ctrl_i,
  input  alu_fn_e           alu_fn_i,
  input  logic              pc_branch_i,
  output logic [XLEN-1:0]   instr_o,
  output logic              zero_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc_q, pc_next, pc_inc, instr;
  logic [REG_AW-1:0] rs, rt, rd, waddr;
  logic [XLEN-1:0]   se_imm, rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
  logic              rf_we, st_we;
  logic              unused_shamt;

  // fetch
  assign pc_inc  = pc_q + XLEN'(4);
  assign instr   = imem[pc_q[IAW+1:2]];
  assign instr_o = instr;

  // field split
  assign rs           = instr[25:21];
  assign rt           = instr[20:16];
  assign rd           = instr[15:11];
  assign se_imm       = {{16{instr[15]}}, instr[15:0]};
  assign unused_shamt = ^instr[10:6];

  assign waddr = ctrl_i.reg_dst ? rd : rt;
  assign rf_we = ctrl_i.reg_write & rst_ni;

  sc_cpu_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (waddr),
    .wdata_i   (wb_val),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  assign alu_b = ctrl_i.alu_imm ? se_imm : rt_val;

  sc_cpu_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .fn_i   (alu_fn_i),
    .y_o    (alu_y),
    .zero_o (zero_o)
  );

  // data store
  assign ld_val = dmem[alu_y[DAW+1:2]];
  assign wb_val = ctrl_i.mem_to_reg ? ld_val : alu_y;
  assign st_we  = ctrl_i.mem_write & rst_ni & ~load_en_i;

  always_ff @(posedge clk_i) begin
    if (load_en_i && load_dmem_i) dmem[load_addr_i[DAW-1:0]] <= load_data_i;
    else if (st_we)               dmem[alu_y[DAW+1:2]]      <= rt_val;
  end

  always_ff @(posedge clk_i) begin
    if (load_en_i && !load_dmem_i) imem[load_addr_i[IAW-1:0]] <= load_data_i;
  end

  // next pc
  always_comb begin
    if (ctrl_i.jump)      pc_next = {pc_inc[31:28], instr[25:0], 2'b00};
    else if (pc_branch_i) pc_next = pc_inc + {se_imm[29:0], 2'b00};
    else                  pc_next = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we & (waddr != '0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = st_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_cpu_core.sv
`timescale 1ns/1ps
module sc_cpu_core
  import sc_cpu_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS),
  localparam int LAW        = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_dmem_i,
  input  logic [LAW-1:0]    load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   instr_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic            pc_branch, zero;
  logic [XLEN-1:0] instr;

  sc_cpu_ctrl u_ctrl (
    .opcode_i    (instr[31:26]),
    .funct_i     (instr[5:0]),
    .zero_i      (zero),
    .ctrl_o      (ctrl),
    .alu_fn_o    (alu_fn),
    .pc_branch_o (pc_branch)
  );

  sc_cpu_dpath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .LAW        (LAW)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_dmem_i (load_dmem_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .ctrl_i      (ctrl),
    .alu_fn_i    (alu_fn),
    .pc_branch_i (pc_branch),
    .instr_o     (instr),
    .zero_o      (zero),
    .pc_o        (pc_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .dm_we_o     (dm_we_o),
    .dm_addr_o   (dm_addr_o),
    .dm_wdata_o  (dm_wdata_o)
  );

  assign instr_o = instr;
endmodule

// File: rtl/sc_cpu_core_chk.sv
`timescale 1ns/1ps
module sc_cpu_core_chk
  import sc_cpu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   instr_o,
  input logic              rf_we_o,
  input logic [REG_AW-1:0] rf_waddr_o,
  input logic              dm_we_o
);
  logic [5:0]      op;
  logic            known_op;
  logic [XLEN-1:0] pc_plus;

  assign op       = instr_o[31:26];
  assign known_op = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) ||
                    (op == OP_BEQ) || (op == OP_J);
  assign pc_plus  = pc_o + XLEN'(4);

  // R1
  reset_pc_chk: assert property (@(posedge clk_i) !rst_ni |-> (pc_o == '0 && !rf_we_o && !dm_we_o));

  // R4
  no_zero_reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != '0);

  // R9
  bad_op_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |-> (!rf_we_o && !dm_we_o));

  // R6
  store_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_SW |-> dm_we_o);

  // R11
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> pc_o == $past(pc_plus));

  // R8
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_J |=> pc_o == {$past(pc_plus[31:28]), $past(instr_o[25:0]), 2'b00});

  // R11
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

bind sc_cpu_core sc_cpu_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_o       (pc_o),
  .instr_o    (instr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/sc_cpu_core_test.sv
`timescale 1ns/1ps
module sc_cpu_core_test;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en = 1'b0, load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc, instr, rf_wdata, dm_addr, dm_wdata;
  logic        rf_we, dm_we;
  logic [4:0]  rf_waddr;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] prog [16];
  logic [31:0] dinit [8];

  always #2.5 clk = ~clk;

  sc_cpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_en_i(load_en), .load_dmem_i(load_dmem),
    .load_addr_i(load_addr), .load_data_i(load_data), .pc_o(pc), .instr_o(instr),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .dm_we_o(dm_we), .dm_addr_o(dm_addr), .dm_wdata_o(dm_wdata)
  );

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s pc=%h act=%h exp=%h", req, pc, act, exp);
    end
  endtask

  task automatic exp_wb(string req, logic [31:0] epc, logic [4:0] wa, logic [31:0] wd);
    chk({req, " pc"}, pc, epc);
    chk({req, " rf_we"}, 32'(rf_we), 32'd1);
    chk({req, " waddr"}, 32'(rf_waddr), 32'(wa));
    chk({req, " wdata"}, rf_wdata, wd);
    chk({req, " dm_we"}, 32'(dm_we), 32'd0);
  endtask

  task automatic exp_quiet(string req, logic [31:0] epc);
    chk({req, " pc"}, pc, epc);
    chk({req, " rf_we"}, 32'(rf_we), 32'd0);
    chk({req, " dm_we"}, 32'(dm_we), 32'd0);
  endtask

  task automatic exp_st(string req, logic [31:0] epc, logic [31:0] ea, logic [31:0] ed);
    chk({req, " pc"}, pc, epc);
    chk({req, " rf_we"}, 32'(rf_we), 32'd0);
    chk({req, " dm_we"}, 32'(dm_we), 32'd1);
    chk({req, " daddr"}, dm_addr, ea);
    chk({req, " ddata"}, dm_wdata, ed);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R10 preload under reset, R1 checks while held
  task automatic boot(int n);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 pc in reset", pc, 32'd0);
    for (int i = 0; i < IW; i++) begin
      load_en = 1'b1; load_dmem = 1'b0; load_addr = 6'(i);
      load_data = (i < n) ? prog[i] : 32'd0;
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      load_en = 1'b1; load_dmem = 1'b1; load_addr = 6'(i); load_data = dinit[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    #1;
    chk("R1 pc held", pc, 32'd0);
    chk("R1 no rf write", 32'(rf_we), 32'd0);
    chk("R1 no store", 32'(dm_we), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic set_data();
    dinit[0] = 32'd7;        dinit[1] = 32'hFFFF_FFFD;
    dinit[2] = 32'h18;       dinit[3] = 32'd0;
    dinit[4] = 32'd0;        dinit[5] = 32'hCAFE_F00D;
    dinit[6] = 32'd5;        dinit[7] = 32'd0;
  endtask

  task automatic t_alu();
    set_data();
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 6'h25);
    prog[6]  = enc_r(2, 1, 7, 6'h2A);
    prog[7]  = enc_r(1, 2, 8, 6'h2A);
    prog[8]  = enc_r(1, 1, 0, 6'h20);
    prog[9]  = enc_i(6'h2B, 0, 0, 16'd12);
    prog[10] = enc_i(6'h3F, 1, 2, 16'd4);
    prog[11] = enc_r(1, 2, 9, 6'h00);
    boot(12);
    exp_wb("R5 R10 lw r1", 32'd0, 5'd1, 32'd7);         step();
    exp_wb("R5 R10 lw r2", 32'd4, 5'd2, 32'hFFFF_FFFD); step();
    exp_wb("R2 add", 32'd8, 5'd3, 32'd4);              step();
    exp_wb("R2 sub", 32'd12, 5'd4, 32'd10);            step();
    exp_wb("R2 and", 32'd16, 5'd5, 32'd5);             step();
    exp_wb("R2 or", 32'd20, 5'd6, 32'hFFFF_FFFF);      step();
    exp_wb("R3 slt true", 32'd24, 5'd7, 32'd1);        step();
    exp_wb("R3 slt false", 32'd28, 5'd8, 32'd0);       step();
    exp_quiet("R4 write r0", 32'd32);                  step();
    exp_st("R4 r0 reads zero", 32'd36, 32'd12, 32'd0); step();
    exp_quiet("R9 bad opcode", 32'd40);                step();
    exp_quiet("R9 bad funct", 32'd44);                 step();
    chk("R11 pc after bad funct", pc, 32'd48);
  endtask

  task automatic t_mem();
    set_data();
    prog[0] = enc_i(6'h23, 0, 9, 16'd8);
    prog[1] = enc_i(6'h23, 9, 10, 16'hFFFC);
    prog[2] = enc_i(6'h2B, 9, 10, 16'hFFF8);
    prog[3] = enc_i(6'h23, 0, 11, 16'd16);
    prog[4] = enc_i(6'h2B, 9, 9, 16'd0);
    boot(5);
    exp_wb("R5 lw base", 32'd0, 5'd9, 32'h18);                   step();
    exp_wb("R5 lw neg offset", 32'd4, 5'd10, 32'hCAFE_F00D);     step();
    exp_st("R6 sw neg offset", 32'd8, 32'h10, 32'hCAFE_F00D);    step();
    exp_wb("R6 reload stored", 32'd12, 5'd11, 32'hCAFE_F00D);    step();
    exp_st("R6 sw base", 32'd16, 32'h18, 32'h18);                step();
    chk("R11 pc step", pc, 32'd20);
  endtask

  task automatic t_branch();
    set_data();
    for (int i = 0; i < 16; i++) prog[i] = 32'd0;
    prog[0]  = enc_i(6'h23, 0, 1, 16'd24);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd24);
    prog[2]  = enc_i(6'h04, 1, 2, 16'd2);
    prog[5]  = enc_i(6'h04, 1, 0, 16'd5);
    prog[6]  = enc_j(26'd12);
    prog[12] = enc_i(6'h04, 0, 0, 16'hFFF3);
    boot(13);
    exp_wb("R5 lw r1", 32'd0, 5'd1, 32'd5);  step();
    exp_wb("R5 lw r2", 32'd4, 5'd2, 32'd5);  step();
    exp_quiet("R7 beq taken", 32'd8);        step();
    exp_quiet("R7 beq not taken", 32'd20);   step();
    exp_quiet("R8 jump", 32'd24);            step();
    exp_quiet("R8 jump target", 32'd48);     step();
    exp_wb("R7 backward branch", 32'd0, 5'd1, 32'd5);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_alu();
    t_mem();
    t_branch();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule